// File: doc/BRIEF.md
# Video Blanking-Region Byte Filter

This block sits on an 8-bit digital video byte stream laid out in the BT.656 style, taking one byte per clock when a valid strobe is high. It watches the stream for embedded timing codes. Each code is three fixed preamble bytes followed by a status byte. From the status bytes it tracks which field is current, whether the line is a vertical-blanking line, and whether the stream is inside the active picture region or in horizontal blanking.

A 2-bit capture mode then picks which bytes go out on a downstream write port. The port carries a byte, a valid strobe and a line-start marker. The three policies are:
- picture samples only, with every timing code removed;
- everything on vertical-blanking lines, which includes their codes, horizontal blanking and ancillary packets;
- the whole field.

A new mode is adopted only where the field flag toggles, so no field is ever captured under two policies. The line-start marker lets the consumer count lines without parsing codes itself.

Top module: `vidblank_filter`

## Requirements
- R1: After reset nothing is forwarded and out_vld and out_line_start are low. Forwarding stays off up to and including the status byte of the first complete timing code. That code is 0xFF, 0x00, 0x00 followed by a status byte. Bytes before it, including a broken preamble, produce no output.
- R2: The status byte is decoded as follows. Bit 6 is the field flag F. Bit 5 is the vertical-blanking flag V. Bit 4 is H, where 1 marks end of active video (EAV) and 0 marks start of active video (SAV). The bits 3..0 are ignored. The decoded flags hold until the next status byte. A preamble that breaks off before its status byte leaves the flags unchanged.
- R3: In mode 2'b00 (picture only), a byte is forwarded only when all of these hold: it arrives after an SAV status, it arrives before the next EAV, the latched V is 0, and it is not part of a timing code. The 0xFF, 0x00, 0x00 preamble that ends a picture run is never forwarded.
- R4: In mode 2'b01 (blanking lines only), every byte that arrives while the latched V is 1 is forwarded. This includes timing-code bytes, horizontal blanking and ancillary data. The bytes of a timing code, its own status byte included, are judged by the V value in force before that status byte.
- R5: In mode 2'b10 (whole field), every byte accepted after synchronisation is forwarded. Mode 2'b11 behaves the same as 2'b10.
- R6: The mode input is adopted at two points. The first is the status byte that first synchronises the block. The second is any later status byte whose F differs from the latched F. That status byte is still judged under the old mode. A mode change inside a field has no effect on the rest of that field.
- R7: out_line_start is high together with the first forwarded byte after each EAV status byte, and low at all other times.
- R8: A forwarded byte appears on out_byte with out_vld one clock after the clock edge that accepted it. Bytes keep their input order. A cycle with in_vld low produces no output.
- R9: Ancillary packets in horizontal blanking are treated like other blanking bytes, for example 0x00, 0xFF, 0xFF followed by header and payload. They follow the mode rules and do not alter the latched flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_byte | input | 8 | Incoming video stream byte |
| in_vld | input | 1 | in_byte is valid this cycle |
| mode_cfg | input | 2 | Requested capture mode (00 picture, 01 blanking lines, 10/11 whole field) |
| out_byte | output | 8 | Forwarded byte |
| out_vld | output | 1 | out_byte is valid this cycle |
| out_line_start | output | 1 | First forwarded byte after an end-of-active-video code |

## Verification
The bench goes after several corner cases. Each one maps to a specific way a broken design would show up:
- The EAV preamble arrives while the active-region flag is still set. A design that tests only the latched flags would leak 0xFF 0x00 0x00 into picture-only output.
- Mode changes are requested in the middle of a field. A filter that adopts the mode at once, or one step too late, forwards the wrong set of lines for part of a field.
- The stream contains ancillary packets and broken preambles in blanking. A careless preamble tracker would take these as codes and corrupt V or the active-region flag.
- Idle cycles appear between bytes. These expose any output that is not tied one-to-one to an accepted byte.
- The line-start marker is checked on the V transitions. A marker cleared on the wrong event would vanish or land on a later byte.

// File: rtl/vidblank_pkg.sv
package vidblank_pkg;

    typedef enum logic [1:0] {
        CAP_PICTURE = 2'b00,
        CAP_VBLANK  = 2'b01,
        CAP_FIELD   = 2'b10,
        CAP_FIELD2  = 2'b11
    } cap_mode_e;

    typedef enum logic [1:0] {
        PRE_IDLE  = 2'd0,
        PRE_ONES  = 2'd1,
        PRE_ZERO1 = 2'd2,
        PRE_ZERO2 = 2'd3
    } pre_state_e;

    typedef struct packed {
        logic       sync;
        logic       fld;
        logic       vblank;
        logic       in_pic;
        logic [1:0] mode;
    } track_t;

endpackage

// File: rtl/vidblank_trc_detect.sv
module vidblank_trc_detect
    import vidblank_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int F_POS  = 6,
    parameter int V_POS  = 5,
    parameter int H_POS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_vld,
    output logic              is_code,
    output logic              stat_stb,
    output logic              stat_f,
    output logic              stat_v,
    output logic              stat_h
);
    localparam logic [BYTE_W-1:0] ALL_ONES  = '1;
    localparam logic [BYTE_W-1:0] ALL_ZEROS = '0;

    pre_state_e st_d, st_q;

    always_comb begin
        st_d     = st_q;
        is_code  = 1'b0;
        stat_stb = 1'b0;
        if (in_vld) begin
            if (st_q == PRE_ZERO2) begin
                is_code  = 1'b1;
                stat_stb = 1'b1;
                st_d     = PRE_IDLE;
            end else if (in_byte == ALL_ONES) begin
                is_code = 1'b1;
                st_d    = PRE_ONES;
            end else if (st_q == PRE_ONES && in_byte == ALL_ZEROS) begin
                is_code = 1'b1;
                st_d    = PRE_ZERO1;
            end else if (st_q == PRE_ZERO1 && in_byte == ALL_ZEROS) begin
                is_code = 1'b1;
                st_d    = PRE_ZERO2;
            end else begin
                st_d = PRE_IDLE;
            end
        end
    end

    assign stat_f = in_byte[F_POS];
    assign stat_v = in_byte[V_POS];
    assign stat_h = in_byte[H_POS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PRE_IDLE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/vidblank_tracker.sv
module vidblank_tracker
    import vidblank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_stb,
    input  logic       stat_f,
    input  logic       stat_v,
    input  logic       stat_h,
    input  logic [1:0] mode_cfg,
    output track_t     trk_q
);
    track_t trk_d;

    always_comb begin
        trk_d = trk_q;
        if (stat_stb) begin
            if (!trk_q.sync || (stat_f != trk_q.fld)) trk_d.mode = mode_cfg;
            trk_d.sync   = 1'b1;
            trk_d.fld    = stat_f;
            trk_d.vblank = stat_v;
            trk_d.in_pic = ~stat_h;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '{sync: 1'b0, fld: 1'b0, vblank: 1'b0, in_pic: 1'b0, mode: CAP_PICTURE};
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/vidblank_fwd.sv
module vidblank_fwd
    import vidblank_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_vld,
    input  logic              is_code,
    input  logic              stat_stb,
    input  logic              stat_h,
    input  track_t            trk,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_vld,
    output logic              out_line_start
);
    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
        logic              lstart;
        logic              pend;
    } fwd_t;

    fwd_t f_d, f_q;
    logic take;

    always_comb begin
        take = 1'b0;
        if (in_vld && trk.sync) begin
            case (cap_mode_e'(trk.mode))
                CAP_PICTURE: take = trk.in_pic && !trk.vblank && !is_code;
                CAP_VBLANK:  take = trk.vblank;
                default:     take = 1'b1;
            endcase
        end

        f_d        = f_q;
        f_d.vld    = take;
        f_d.lstart = take && f_q.pend;
        if (take) begin
            f_d.data = in_byte;
            f_d.pend = 1'b0;
        end
        if (stat_stb && stat_h) f_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign out_byte       = f_q.data;
    assign out_vld        = f_q.vld;
    assign out_line_start = f_q.lstart;

endmodule

// File: rtl/vidblank_filter.sv
module vidblank_filter
    import vidblank_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int F_POS  = 6,
    parameter int V_POS  = 5,
    parameter int H_POS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_vld,
    input  logic [1:0]        mode_cfg,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_vld,
    output logic              out_line_start
);
    logic   is_code, stat_stb, stat_f, stat_v, stat_h;
    track_t trk_q;

    vidblank_trc_detect #(
        .BYTE_W(BYTE_W), .F_POS(F_POS), .V_POS(V_POS), .H_POS(H_POS)
    ) u_detect (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_vld(in_vld),
        .is_code(is_code), .stat_stb(stat_stb),
        .stat_f(stat_f), .stat_v(stat_v), .stat_h(stat_h)
    );

    vidblank_tracker u_track (
        .clk(clk), .rst_n(rst_n), .stat_stb(stat_stb),
        .stat_f(stat_f), .stat_v(stat_v), .stat_h(stat_h),
        .mode_cfg(mode_cfg), .trk_q(trk_q)
    );

    vidblank_fwd #(.BYTE_W(BYTE_W)) u_fwd (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_vld(in_vld),
        .is_code(is_code), .stat_stb(stat_stb), .stat_h(stat_h), .trk(trk_q),
        .out_byte(out_byte), .out_vld(out_vld), .out_line_start(out_line_start)
    );

endmodule

// File: rtl/vidblank_chk.sv
module vidblank_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] in_byte,
    input logic              in_vld,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_vld,
    input logic              out_line_start,
    input logic              is_code,
    input logic              stat_stb,
    input logic              stat_f,
    input logic              trk_sync,
    input logic              trk_fld,
    input logic              trk_vblank,
    input logic [1:0]        trk_mode
);
    // R1
    presync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trk_sync |=> !out_vld);

    // R3
    picture_code_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && is_code && trk_sync && trk_mode == 2'b00) |=> !out_vld);

    // R4
    vblank_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && trk_sync && trk_mode == 2'b01 && trk_vblank) |=> (out_vld && out_byte == $past(in_byte)));

    // R5
    field_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && trk_sync && trk_mode[1]) |=> (out_vld && out_byte == $past(in_byte)));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_sync && !(stat_stb && stat_f != trk_fld)) |=> $stable(trk_mode));

    // R7
    lstart_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_line_start |-> out_vld);

    // R8
    no_idle_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

endmodule

bind vidblank_filter vidblank_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_vld(in_vld),
    .out_byte(out_byte), .out_vld(out_vld), .out_line_start(out_line_start),
    .is_code(is_code), .stat_stb(stat_stb), .stat_f(stat_f),
    .trk_sync(trk_q.sync), .trk_fld(trk_q.fld), .trk_vblank(trk_q.vblank),
    .trk_mode(trk_q.mode)
);

// File: tb/vidblank_filter_tb_top.sv
module vidblank_filter_tb_top;
    localparam int K_BLANK = 0;
    localparam int K_PIC   = 1;
    localparam int K_PRE   = 2;
    localparam int K_STAT  = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] in_byte;
    logic       in_vld;
    logic [1:0] mode_cfg;
    logic [7:0] out_byte;
    logic       out_vld;
    logic       out_line_start;

    always #5 clk = ~clk;

    vidblank_filter dut_i (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_vld(in_vld),
        .mode_cfg(mode_cfg), .out_byte(out_byte), .out_vld(out_vld),
        .out_line_start(out_line_start)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    int n_put = 0;
    int line_id = 0;

    logic [7:0] q_b[$];
    bit         q_ls[$];
    int         q_t[$];
    string      q_tag[$];

    bit         m_sync = 0, m_v = 0, m_f = 0, m_pend = 0;
    logic [1:0] m_mode = 2'b00;

    always @(posedge clk) cyc++;

    function automatic logic [7:0] stat_byte(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic put(input logic [7:0] b, input int k);
        bit    fwd;
        string tag;
        fwd = 0;
        tag = "R5";
        if (m_sync) begin
            if (m_mode == 2'b00) begin fwd = (k == K_PIC) && !m_v; tag = "R3"; end
            else if (m_mode == 2'b01) begin fwd = m_v; tag = "R4"; end
            else begin fwd = 1; tag = "R5"; end
        end
        if (fwd) begin
            q_b.push_back(b);
            q_ls.push_back(m_pend);
            q_t.push_back(cyc + 1);
            q_tag.push_back(m_pend ? "R7" : tag);
            m_pend = 0;
        end
        if (k == K_STAT) begin
            if (!m_sync || b[6] != m_f) m_mode = mode_cfg;
            m_sync = 1;
            m_v = b[5];
            m_f = b[6];
            if (b[4]) m_pend = 1;
        end
        in_byte = b;
        in_vld  = 1'b1;
        @(posedge clk); #1;
        in_vld  = 1'b0;
        n_put++;
        if (n_put % 7 == 0) begin @(posedge clk); #1; end   // R8 idle gaps
    endtask

    task automatic trc(input bit f, input bit v, input bit h);
        put(8'hFF, K_PRE);
        put(8'h00, K_PRE);
        put(8'h00, K_PRE);
        put(stat_byte(f, v, h), K_STAT);
    endtask

    task automatic vline(input bit f, input bit v, input bit anc, input bit brk);
        trc(f, v, 1'b1);
        for (int i = 0; i < 6; i++) put((i % 2) ? 8'h10 : 8'h80, K_BLANK);
        if (anc) begin
            // R9 ancillary packet inside horizontal blanking
            put(8'h00, K_BLANK); put(8'hFF, K_BLANK); put(8'hFF, K_BLANK);
            put(8'h45, K_BLANK); put(8'h03, K_BLANK);
            put(8'h11, K_BLANK); put(8'h22, K_BLANK); put(8'h33, K_BLANK);
            put(8'h5A, K_BLANK);
        end
        if (brk) begin
            // R2 broken preamble must not disturb the flags
            put(8'hFF, K_BLANK); put(8'h00, K_BLANK); put(8'h37, K_BLANK);
        end
        trc(f, v, 1'b0);
        for (int i = 0; i < 8; i++) put(8'h40 + 8'(i) + 8'((line_id % 16) * 8), K_PIC);
        line_id++;
    endtask

    task automatic field(input bit f, input logic [1:0] next_mode);
        vline(f, 1'b1, 1'b1, 1'b0);
        vline(f, 1'b1, 1'b0, 1'b1);
        mode_cfg = next_mode;   // R6 request mid-field, adopted at next F toggle
        vline(f, 1'b0, 1'b1, 1'b0);
        vline(f, 1'b0, 1'b0, 1'b1);
        vline(f, 1'b0, 1'b0, 1'b0);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            n_vec++;
            if (q_b.size() == 0) begin
                n_bad++;
                $display("FAIL R8: unexpected output byte %h (expected no output)", out_byte);
            end else begin
                logic [7:0] eb;
                bit         els;
                int         et;
                string      tg;
                eb = q_b.pop_front();
                els = q_ls.pop_front();
                et = q_t.pop_front();
                tg = q_tag.pop_front();
                if (out_byte !== eb || out_line_start !== els) begin
                    n_bad++;
                    $display("FAIL %s: byte/lstart %h/%b expected %h/%b", tg, out_byte, out_line_start, eb, els);
                end else if (cyc != et) begin
                    n_bad++;
                    $display("FAIL R8: byte %h at cycle %0d expected cycle %0d", out_byte, cyc, et);
                end
            end
        end else if (rst_n && out_line_start) begin
            n_vec++;
            n_bad++;
            $display("FAIL R7: line start without valid (expected 0)");
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not finish (expected completion)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_byte  = 8'h00;
        in_vld   = 1'b0;
        mode_cfg = 2'b10;
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (out_vld !== 1'b0 || out_line_start !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: reset outputs %b/%b expected 0/0", out_vld, out_line_start);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 junk and a broken preamble before sync: no output
        put(8'h10, K_BLANK); put(8'h55, K_BLANK);
        put(8'hFF, K_BLANK); put(8'h00, K_BLANK); put(8'h12, K_BLANK);

        field(1'b0, 2'b00);   // whole field; R3 picture-only requested
        field(1'b1, 2'b01);   // picture only; R4 blanking lines requested
        field(1'b0, 2'b11);   // blanking lines; R5 alternate whole-field code
        field(1'b1, 2'b00);   // whole field via 2'b11
        field(1'b0, 2'b00);   // picture only again
        vline(1'b1, 1'b1, 1'b0, 1'b0);

        repeat (4) @(posedge clk);
        #2;
        n_vec++;
        if (q_b.size() != 0) begin
            n_bad++;
            $display("FAIL R8: %0d expected bytes never produced (expected 0)", q_b.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule